// File: doc/BRIEF.md
# Sample-Phase Timing Programmer

This block sets up the sampling and drive phases of an SD or SDIO host controller whenever the bus timing mode changes. A request names the controller kind (SD or SDIO), a bus timing mode index and, if wanted, an explicit sample phase. The block looks the mode up in a built-in timing table and chooses the sample phase. It then decides whether the sampling shift and the extra sample delay are needed. Last, it reprograms the controller through a sequence of four register writes with set waits between them.

The order of writes keeps the card clock off while the phase fields change. First the clock-control register is cleared and a short gate wait runs. Next come the phase-extension register and the shift-enable register. Last, the clock is re-enabled with a fixed divider, and a long settle wait runs before `done` pulses. Writes leave on a valid/ready bus that carries one address and one data word per beat. `wr_valid` rises with a beat and holds it, address and data steady, until `wr_ready` is seen high on a clock edge. `wr_ready` may stall any beat for any number of cycles and has no effect while `wr_valid` is low. The sequence moves forward only on an accepted beat.

Top module: `smpl_phase_prog`

## Requirements
- R1: With `ovr_en` low, the sample phase is floor((max+min)/2) of the table window for the selected controller and mode.
- R2: With `ovr_en` high, the sample phase is `ovr_phase` (5 bits) unchanged, and the drive phase and delay still come from the table.
- R3: The shift flag is 1 only in mode SDR50 (code 5) or SDR104 (code 6) with a sample phase from 4 to 12 inclusive. The shift-register write carries the flag in bit 0 and zeros above it.
- R4: The use-delay flag is 1 only in mode SDR104 (code 6) with a sample phase from 11 to 14 inclusive. In every mode other than codes 5 and 6, both flags are 0.
- R5: One request produces exactly four accepted writes, in this order: clock-control (address `ADDR_CLK`) with data 0, extension (`ADDR_EXT`), shift (`ADDR_SHIFT`), clock-control again.
- R6: The extension word holds the sample phase in bits 20:16, the drive phase in bits 25:21 and the sample delay in bits 30:26. All other bits are 0.
- R7: The final clock-control word holds the divider 7 in bits 11:8, the use-delay flag in bit 13 and the clock enable in bit 16. All other bits are 0, so the word is 0x00010700 or 0x00012700.
- R8: The extension write is presented exactly GATE_CYC = (CLK_HZ/1e6)*GATE_US cycles after the first write is accepted. The shift and final clock writes follow each acceptance in the next cycle.
- R9: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse, with `busy` low, exactly SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US cycles after the final write is accepted.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady. `wr_valid` is high only while `busy`.
- R11: A `start` seen while `busy` is ignored: it causes no extra writes, does not change the words of the request in progress, and causes no extra `done`.
- R12: After reset, `busy`, `done` and `wr_valid` are 0.
- R13: Table (drive, delay, window max, window min). Controller 0 is SD, 1 is SDIO. Mode 0: SD 7,0,15,15. Mode 2: SD 6,0,3,3. Mode 5: SD 4,0,11,0 and SDIO 4,0,12,0. Mode 6: SD 6,4,15,0 and SDIO 5,4,15,0. Modes 7 to 15 are all zero for both controllers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; taken only while idle |
| ctrl_sel | input | 1 | 0 = SD controller, 1 = SDIO controller |
| mode | input | 4 | Bus timing mode index |
| ovr_en | input | 1 | Use `ovr_phase` instead of the table average |
| ovr_phase | input | 5 | Explicit sample phase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Register bus accepts the beat |
| wr_addr | output | 12 | Register address of the beat |
| wr_data | output | 32 | Register data of the beat |

## Verification
Default-phase requests in the legacy, SDR50 and SDR104 modes on both controllers show that the table rows differ and that the averaging is right. Explicit phases of 3, 4, 11, 12, 13, 14 and 15 sit on each side of both flag windows, which separates the shift rule from the delay rule. The same phase in a high-speed mode shows that flags apply only in SDR50 and SDR104. A mode outside the table, a stalled-ready run, and a start pulse sent mid-sequence check the zero row, the holding of each beat and the rejection of starts while busy.

// File: rtl/sphase_pkg.sv
package sphase_pkg;
  localparam int PH_W   = 5;
  localparam int MODE_W = 4;
  localparam int N_CTRL = 2;

  localparam logic [MODE_W-1:0] MODE_LEGACY = 4'd0;
  localparam logic [MODE_W-1:0] MODE_MMCHS  = 4'd1;
  localparam logic [MODE_W-1:0] MODE_SDHS   = 4'd2;
  localparam logic [MODE_W-1:0] MODE_SDR12  = 4'd3;
  localparam logic [MODE_W-1:0] MODE_SDR25  = 4'd4;
  localparam logic [MODE_W-1:0] MODE_SDR50  = 4'd5;
  localparam logic [MODE_W-1:0] MODE_SDR104 = 4'd6;

  // extension word field positions (decoded by the controller)
  localparam int EXT_PH_LSB  = 16;
  localparam int EXT_DRV_LSB = 21;
  localparam int EXT_DLY_LSB = 26;

  // clock-control word field positions
  localparam int CK_DIV_LSB = 8;
  localparam int CK_DIV_W   = 4;
  localparam int CK_DLY_BIT = 13;
  localparam int CK_EN_BIT  = 16;
  localparam logic [CK_DIV_W-1:0] CK_DIV_VAL = 4'd7;

  // flag windows (inclusive)
  localparam int SHIFT_LO = 4;
  localparam int SHIFT_HI = 12;
  localparam int UDLY_LO  = 11;
  localparam int UDLY_HI  = 14;

  typedef struct packed {
    logic [PH_W-1:0] drv;
    logic [PH_W-1:0] dly;
    logic [PH_W-1:0] pmax;
    logic [PH_W-1:0] pmin;
  } tcfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATE, ST_GWAIT, ST_EXT, ST_SHIFT, ST_CLK, ST_SETTLE
  } st_e;

  function automatic tcfg_t mk_row(input int drv, input int dly, input int pmax, input int pmin);
    tcfg_t r;
    r.drv  = PH_W'(drv);
    r.dly  = PH_W'(dly);
    r.pmax = PH_W'(pmax);
    r.pmin = PH_W'(pmin);
    return r;
  endfunction
endpackage

// File: rtl/sphase_table.sv
module sphase_table
  import sphase_pkg::*;
(
  input  logic              ctrl,
  input  logic [MODE_W-1:0] mode,
  output tcfg_t             cfg
);
  function automatic tcfg_t row_sd(input logic [MODE_W-1:0] m);
    case (m)
      MODE_LEGACY: return mk_row(7, 0, 15, 15);
      MODE_MMCHS:  return mk_row(6, 0, 4, 4);
      MODE_SDHS:   return mk_row(6, 0, 3, 3);
      MODE_SDR12:  return mk_row(6, 0, 15, 15);
      MODE_SDR25:  return mk_row(6, 0, 2, 2);
      MODE_SDR50:  return mk_row(4, 0, 11, 0);
      MODE_SDR104: return mk_row(6, 4, 15, 0);
      default:     return '0;
    endcase
  endfunction

  function automatic tcfg_t row_sdio(input logic [MODE_W-1:0] m);
    case (m)
      MODE_LEGACY: return mk_row(7, 0, 15, 15);
      MODE_SDHS:   return mk_row(6, 0, 15, 15);
      MODE_SDR12:  return mk_row(6, 0, 15, 15);
      MODE_SDR25:  return mk_row(6, 0, 0, 0);
      MODE_SDR50:  return mk_row(4, 0, 12, 0);
      MODE_SDR104: return mk_row(5, 4, 15, 0);
      default:     return '0;
    endcase
  endfunction

  tcfg_t rows [N_CTRL];

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    if (g == 0) begin : g_sd
      assign rows[g] = row_sd(mode);
    end else begin : g_sdio
      assign rows[g] = row_sdio(mode);
    end
  end

  assign cfg = rows[ctrl];
endmodule

// File: rtl/sphase_calc.sv
module sphase_calc
  import sphase_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  tcfg_t              cfg,
  input  logic [MODE_W-1:0]  mode,
  input  logic               ovr_en,
  input  logic [PH_W-1:0]    ovr_ph,
  output logic [DATA_W-1:0]  ext_word,
  output logic [DATA_W-1:0]  shift_word,
  output logic [DATA_W-1:0]  clk_word
);
  logic [PH_W:0]   win_sum;
  logic [PH_W-1:0] phase;
  logic            in_shift, in_udly, shift_en, use_dly;

  always_comb begin
    win_sum  = {1'b0, cfg.pmax} + {1'b0, cfg.pmin};
    phase    = ovr_en ? ovr_ph : win_sum[PH_W:1];
    in_shift = (phase >= PH_W'(SHIFT_LO)) && (phase <= PH_W'(SHIFT_HI));
    in_udly  = (phase >= PH_W'(UDLY_LO)) && (phase <= PH_W'(UDLY_HI));
    // SDR104 applies its own delay rule plus the SDR50 shift rule
    shift_en = ((mode == MODE_SDR50) || (mode == MODE_SDR104)) && in_shift;
    use_dly  = (mode == MODE_SDR104) && in_udly;

    ext_word = '0;
    ext_word[EXT_PH_LSB  +: PH_W] = phase;
    ext_word[EXT_DRV_LSB +: PH_W] = cfg.drv;
    ext_word[EXT_DLY_LSB +: PH_W] = cfg.dly;

    shift_word    = '0;
    shift_word[0] = shift_en;

    clk_word = '0;
    clk_word[CK_DIV_LSB +: CK_DIV_W] = CK_DIV_VAL;
    clk_word[CK_DLY_BIT] = use_dly;
    clk_word[CK_EN_BIT]  = 1'b1;
  end
endmodule

// File: rtl/sphase_seq.sv
module sphase_seq
  import sphase_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                GATE_CYC   = 500,
  parameter int                SETTLE_CYC = 100000,
  parameter logic [ADDR_W-1:0] ADDR_CLK   = 12'h0F0,
  parameter logic [ADDR_W-1:0] ADDR_EXT   = 12'h108,
  parameter logic [ADDR_W-1:0] ADDR_SHIFT = 12'h110
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] ext_word,
  input  logic [DATA_W-1:0] shift_word,
  input  logic [DATA_W-1:0] clk_word,
  output logic              take,
  output logic              busy,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LONGEST = (GATE_CYC > SETTLE_CYC) ? GATE_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] GATE_LD   = CNT_W'(GATE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic             beat;

  assign busy     = (st != ST_IDLE);
  assign take     = start && !busy;
  assign wr_valid = (st == ST_GATE) || (st == ST_EXT) || (st == ST_SHIFT) || (st == ST_CLK);
  assign beat     = wr_valid && wr_ready;

  always_comb begin
    case (st)
      ST_GATE:  begin wr_addr = ADDR_CLK;   wr_data = '0;         end
      ST_EXT:   begin wr_addr = ADDR_EXT;   wr_data = ext_word;   end
      ST_SHIFT: begin wr_addr = ADDR_SHIFT; wr_data = shift_word; end
      ST_CLK:   begin wr_addr = ADDR_CLK;   wr_data = clk_word;   end
      default:  begin wr_addr = '0;         wr_data = '0;         end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE:   if (take) st <= ST_GATE;
        ST_GATE:   if (beat) begin st <= ST_GWAIT; cnt <= GATE_LD; end
        ST_GWAIT:  if (cnt == '0) st <= ST_EXT; else cnt <= cnt - 1'b1;
        ST_EXT:    if (beat) st <= ST_SHIFT;
        ST_SHIFT:  if (beat) st <= ST_CLK;
        ST_CLK:    if (beat) begin st <= ST_SETTLE; cnt <= SETTLE_LD; end
        ST_SETTLE: begin
          if (cnt == '0) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smpl_phase_prog.sv
module smpl_phase_prog
  import sphase_pkg::*;
#(
  parameter int                CLK_HZ     = 100_000_000,
  parameter int                GATE_US    = 5,
  parameter int                SETTLE_US  = 1000,
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] ADDR_CLK   = 12'h0F0,
  parameter logic [ADDR_W-1:0] ADDR_EXT   = 12'h108,
  parameter logic [ADDR_W-1:0] ADDR_SHIFT = 12'h110
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ctrl_sel,
  input  logic [MODE_W-1:0] mode,
  input  logic              ovr_en,
  input  logic [PH_W-1:0]   ovr_phase,
  output logic              busy,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int GATE_RAW   = CYC_PER_US * GATE_US;
  localparam int SETL_RAW   = CYC_PER_US * SETTLE_US;
  localparam int GATE_CYC   = (GATE_RAW < 1) ? 1 : GATE_RAW;
  localparam int SETTLE_CYC = (SETL_RAW < 1) ? 1 : SETL_RAW;

  logic              take;
  logic              q_ctrl, q_oen;
  logic [MODE_W-1:0] q_mode;
  logic [PH_W-1:0]   q_oph;
  tcfg_t             cfg;
  logic [DATA_W-1:0] ext_word, shift_word, clk_word;

  // request captured once; held for the whole sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ctrl <= 1'b0;
      q_oen  <= 1'b0;
      q_mode <= '0;
      q_oph  <= '0;
    end else if (take) begin
      q_ctrl <= ctrl_sel;
      q_oen  <= ovr_en;
      q_mode <= mode;
      q_oph  <= ovr_phase;
    end
  end

  sphase_table u_table (
    .ctrl (q_ctrl),
    .mode (q_mode),
    .cfg  (cfg)
  );

  sphase_calc #(.DATA_W(DATA_W)) u_calc (
    .cfg        (cfg),
    .mode       (q_mode),
    .ovr_en     (q_oen),
    .ovr_ph     (q_oph),
    .ext_word   (ext_word),
    .shift_word (shift_word),
    .clk_word   (clk_word)
  );

  sphase_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GATE_CYC   (GATE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .ADDR_CLK   (ADDR_CLK),
    .ADDR_EXT   (ADDR_EXT),
    .ADDR_SHIFT (ADDR_SHIFT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ext_word   (ext_word),
    .shift_word (shift_word),
    .clk_word   (clk_word),
    .take       (take),
    .busy       (busy),
    .done       (done),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );
endmodule

// File: rtl/sphase_chk.sv
module sphase_chk #(
  parameter int                ADDR_W     = 12,
  parameter int                DATA_W     = 32,
  parameter int                GATE_CYC   = 500,
  parameter logic [ADDR_W-1:0] ADDR_CLK   = 12'h0F0,
  parameter logic [ADDR_W-1:0] ADDR_EXT   = 12'h108,
  parameter logic [ADDR_W-1:0] ADDR_SHIFT = 12'h110
)(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  logic [2:0]  nacc;
  logic [31:0] gcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nacc <= '0;
      gcnt <= '0;
    end else begin
      if (start && !busy) nacc <= '0;
      else if (wr_valid && wr_ready) nacc <= nacc + 1'b1;
      if (wr_valid && wr_ready && nacc == 3'd0) gcnt <= '0;
      else if (gcnt < 32'(GATE_CYC)) gcnt <= gcnt + 1'b1;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((nacc == 3'd0 && wr_addr == ADDR_CLK && wr_data == '0) ||
                  (nacc == 3'd1 && wr_addr == ADDR_EXT) ||
                  (nacc == 3'd2 && wr_addr == ADDR_SHIFT) ||
                  (nacc == 3'd3 && wr_addr == ADDR_CLK)));

  assert_gate_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && nacc == 3'd1 |-> gcnt >= 32'(GATE_CYC));

  assert_shift_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && nacc == 3'd2 |-> wr_data[DATA_W-1:1] == '0);

  assert_clk_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && nacc == 3'd3 |-> wr_data[11:8] == 4'd7 && wr_data[16] && !wr_data[12]);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_valid);

  assert_busy_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind smpl_phase_prog sphase_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .GATE_CYC   (GATE_CYC),
  .ADDR_CLK   (ADDR_CLK),
  .ADDR_EXT   (ADDR_EXT),
  .ADDR_SHIFT (ADDR_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/smpl_phase_prog_tb.sv
module smpl_phase_prog_tb_top;
  // block clock parameter scaled down so the waits stay short: 5 and 1000 cycles
  localparam int G_CYC = 5;
  localparam int S_CYC = 1000;
  localparam logic [31:0] A_CLK = 32'h0F0, A_EXT = 32'h108, A_SH = 32'h110;
  localparam logic [31:0] CK0 = 32'h0001_0700, CK1 = 32'h0001_2700;

  logic        clk = 0, rst_n = 0, start = 0, ctrl_sel = 0, ovr_en = 0, wr_ready = 0;
  logic [3:0]  mode = 0;
  logic [4:0]  ovr_phase = 0;
  logic        busy, done, wr_valid;
  logic [11:0] wr_addr;
  logic [31:0] wr_data;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int nwr = 0, ndone = 0, done_cyc = 0, scnt = 0;
  bit stall_on = 0;
  logic [31:0] wa [0:7];
  logic [31:0] wd [0:7];
  int          wc [0:7];

  smpl_phase_prog #(.CLK_HZ(1_000_000), .GATE_US(5), .SETTLE_US(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_sel(ctrl_sel), .mode(mode),
    .ovr_en(ovr_en), .ovr_phase(ovr_phase), .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

  always #5 clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R9 watchdog: cycle %0d expected below %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // bus sink and monitor: ready chosen at negedge, a beat counts if valid is up too
  always @(negedge clk) begin
    bit rdy;
    scnt++;
    rdy = stall_on ? (scnt % 3 == 2) : 1'b1;
    if (wr_valid && rdy) begin
      if (nwr < 8) begin
        wa[nwr] = 32'(wr_addr); wd[nwr] = wr_data; wc[nwr] = cyc;
      end
      nwr++;
    end
    if (done) begin ndone++; done_cyc = cyc; end
    wr_ready = rdy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit c, input logic [3:0] m, input bit oe, input logic [4:0] op,
                       output int t0);
    @(negedge clk);
    ctrl_sel = c; mode = m; ovr_en = oe; ovr_phase = op; start = 1; t0 = cyc;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && ndone == 0; i++) @(negedge clk);
  endtask

  task automatic run_prog(input string name, input bit c, input logic [3:0] m,
                          input bit oe, input logic [4:0] op,
                          input logic [31:0] e_ext, input logic [31:0] e_sh,
                          input logic [31:0] e_ck, input bit stall);
    int t0;
    nwr = 0; ndone = 0; stall_on = stall;
    issue(c, m, oe, op, t0);
    chk(busy == 1'b1, "R9", {name, " busy after start"}, 32'(busy), 1);
    wait_done();
    chk(nwr == 4, "R5", {name, " write count"}, nwr, 4);
    chk(wa[0] == A_CLK && wd[0] == 0, "R5", {name, " first write clock off"}, wd[0], 0);
    chk(wa[1] == A_EXT, "R5", {name, " second address"}, wa[1], A_EXT);
    chk(wd[1] == e_ext, "R6", {name, " extension word (R1 R2 R13)"}, wd[1], e_ext);
    chk(wa[2] == A_SH, "R5", {name, " third address"}, wa[2], A_SH);
    chk(wd[2] == e_sh, "R3", {name, " shift word"}, wd[2], e_sh);
    chk(wa[3] == A_CLK, "R5", {name, " fourth address"}, wa[3], A_CLK);
    chk(wd[3] == e_ck, "R7", {name, " clock word (R4 delay bit)"}, wd[3], e_ck);
    if (!stall) begin
      chk(wc[0] == t0 + 1, "R8", {name, " first write cycle"}, wc[0] - t0, 1);
      chk(wc[1] - wc[0] == G_CYC + 1, "R8", {name, " gate wait"}, wc[1] - wc[0], G_CYC + 1);
      chk(wc[3] - wc[1] == 2, "R8", {name, " back-to-back writes"}, wc[3] - wc[1], 2);
      chk(done_cyc - wc[3] == S_CYC + 1, "R9", {name, " settle wait"}, done_cyc - wc[3], S_CYC + 1);
    end
    repeat (3) @(negedge clk);
    chk(ndone == 1, "R9", {name, " single done pulse"}, ndone, 1);
    chk(busy == 1'b0, "R9", {name, " idle after done"}, 32'(busy), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_valid, "R12", "outputs in reset", {busy, done, wr_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !wr_valid, "R12", "outputs after reset", {busy, done, wr_valid}, 0);
  endtask

  task automatic t_defaults();
    run_prog("R1 SD legacy",      0, 4'd0, 0, 0, 32'h00EF_0000, 0, CK0, 0);
    run_prog("R1 SD SDR50",       0, 4'd5, 0, 0, 32'h0085_0000, 1, CK0, 0);
    run_prog("R1 SD SDR104",      0, 4'd6, 0, 0, 32'h10C7_0000, 1, CK0, 0);
    run_prog("R13 SDIO SDR50",    1, 4'd5, 0, 0, 32'h0086_0000, 1, CK0, 0);
  endtask

  task automatic t_windows();
    run_prog("R2 SDIO SDR104 p12", 1, 4'd6, 1, 12, 32'h10AC_0000, 1, CK1, 0);
    run_prog("R4 SD SDR104 p13",   0, 4'd6, 1, 13, 32'h10CD_0000, 0, CK1, 0);
    run_prog("R4 SD SDR104 p11",   0, 4'd6, 1, 11, 32'h10CB_0000, 1, CK1, 0);
    run_prog("R4 SD SDR104 p14",   0, 4'd6, 1, 14, 32'h10CE_0000, 0, CK1, 0);
    run_prog("R4 SD SDR104 p15",   0, 4'd6, 1, 15, 32'h10CF_0000, 0, CK0, 0);
    run_prog("R3 SD SDR104 p4",    0, 4'd6, 1, 4,  32'h10C4_0000, 1, CK0, 0);
    run_prog("R3 SD SDR104 p3",    0, 4'd6, 1, 3,  32'h10C3_0000, 0, CK0, 0);
    run_prog("R3 SD SDR50 p12",    0, 4'd5, 1, 12, 32'h008C_0000, 1, CK0, 0);
    run_prog("R3 SD SDR50 p13",    0, 4'd5, 1, 13, 32'h008D_0000, 0, CK0, 0);
  endtask

  task automatic t_other_modes();
    run_prog("R4 SD high-speed p12", 0, 4'd2, 1, 12, 32'h00CC_0000, 0, CK0, 0);
    run_prog("R13 SD mode 9 zero row", 0, 4'd9, 0, 0, 32'h0000_0000, 0, CK0, 0);
  endtask

  task automatic t_stall();
    run_prog("R10 stalled SD SDR104", 0, 4'd6, 1, 12, 32'h10CC_0000, 1, CK1, 1);
    stall_on = 0;
  endtask

  task automatic t_ignore_start();
    int t0;
    nwr = 0; ndone = 0; stall_on = 0;
    issue(0, 4'd6, 0, 0, t0);
    while (nwr < 4) @(negedge clk);
    repeat (10) @(negedge clk);
    issue(1, 4'd5, 1, 9, t0);
    wait_done();
    repeat (30) @(negedge clk);
    chk(nwr == 4, "R11", "no extra writes after busy start", nwr, 4);
    chk(wd[1] == 32'h10C7_0000, "R11", "words of first request kept", wd[1], 32'h10C7_0000);
    chk(ndone == 1, "R11", "no extra done", ndone, 1);
    chk(!busy && !wr_valid, "R11", "idle after ignored start", {busy, wr_valid}, 0);
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_windows();
    t_other_modes();
    t_stall();
    t_ignore_start();
    summary();
    $finish;
  end
endmodule